// File: doc/BRIEF.md
# Programmable Clock Gear Divider

This block turns a fast source clock into a slower system rate. The slower rate is one of five gears: the source rate itself, or the source divided by 2, 4, 8 or 16. It does not make a derived clock. It produces a clock-enable pulse, one source cycle wide, at the selected rate. Logic downstream runs on the source clock and acts only in cycles where the enable is high. At the divide-by-1 gear the enable stays high in every cycle.

A small control register sets the gear. The register sits on the source clock and is written through a strobe, an address-match input and an 8-bit data bus. The same register also holds a system clock source select bit and two oscillator enable bits, and it can be read back at any time. A new gear is not applied at once. The block holds it until its 16-count divider wraps, so every enable period is a whole period of either the old gear or the new one. A completion flag drops on the write and rises when the new gear is in force.

The block also reports a PLL-bypass condition, decoded from the register fields. After reset it runs at the slowest gear. For example, a 10 MHz source gives 625 kHz after reset.

Top module: `clkgear_top`

## Requirements
- R1: After reset the register reads 8'h14. That means gear code 3'b100, select bit 0, high-speed oscillator enable 1 and low-speed oscillator enable 0. The completion flag is high and enable pulses are spaced 16 source cycles apart.
- R2: Gear codes map to pulse spacings as follows: 3'b000 gives a pulse every cycle, 3'b001 every 2 cycles, 3'b010 every 4, 3'b011 every 8 and 3'b100 every 16.
- R3: Gear codes 3'b101, 3'b110 and 3'b111 all give a spacing of 16 cycles.
- R4: The register layout is as follows. Bits [2:0] hold the gear, bit 3 the system clock select, bit 4 the high-speed oscillator enable and bit 5 the low-speed oscillator enable. Bits [7:6] always read 0. A write takes effect only in a cycle where both the strobe and the address match are high. Any other cycle leaves the read data and the completion flag unchanged.
- R5: After a write, pulses keep the old spacing until the 16-count divider wraps. The wrap cycle always carries a pulse. The new spacing starts on the cycle after that wrap pulse.
- R6: The completion flag is low in the cycle after an accepted write. It rises in the cycle right after the divider wrap that applies the gear, and no more than 16 cycles after the write.
- R7: The PLL-bypass output is high exactly when three conditions hold: the high-speed oscillator enable is 1, the select bit is 0 and the gear code is 3'b100. It changes only in the cycle after a write.
- R8: The two oscillator enable outputs follow register bits 4 and 5 from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register address match |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current register contents |
| sys_ce | output | 1 | System clock enable pulse |
| change_done | output | 1 | High when the last written gear is in force |
| pll_off | output | 1 | PLL-bypass mode decoded from the register |
| hosc_en | output | 1 | High-speed oscillator enable |
| losc_en | output | 1 | Low-speed oscillator enable |

## Verification
A write takes effect on the clock edge that samples it. The read data, the oscillator enables and the PLL-bypass output all show the new value at the next falling edge, and that is where the bench compares them. The new gear waits for the divider wrap, so the bench does not guess a fixed delay. It checks every pulse interval against the old spacing until the completion flag rises, requires that rise to come one cycle after the last pulse, and only then queues intervals of the new spacing. A pulse is timed by counting rising edges between two falling-edge samples of the enable.

// File: rtl/clkgear_pkg.sv
package clkgear_pkg;

  localparam int CNT_W   = 4;
  localparam int SHIFT_W = 3;
  localparam int GEAR_W  = 3;
  localparam int DATA_W  = 8;

  typedef logic [SHIFT_W-1:0] shift_t;

  typedef struct packed {
    logic [1:0]        rsvd;
    logic              losc_on;
    logic              hosc_on;
    logic              src_sel;
    logic [GEAR_W-1:0] gear;
  } ctrl_reg_t;

  localparam ctrl_reg_t CTRL_RESET = '{
    rsvd:    2'b00,
    losc_on: 1'b0,
    hosc_on: 1'b1,
    src_sel: 1'b0,
    gear:    3'b100
  };

  // gear code -> log2 of the division ratio; out-of-range codes take the slowest
  function automatic shift_t gear_to_shift(input logic [GEAR_W-1:0] g);
    shift_t s;
    case (g)
      3'b000:  s = 3'd0;
      3'b001:  s = 3'd1;
      3'b010:  s = 3'd2;
      3'b011:  s = 3'd3;
      default: s = 3'd4;
    endcase
    return s;
  endfunction

  // low bits of the divider that must all be one for a pulse
  function automatic logic [CNT_W-1:0] shift_mask(input shift_t s);
    logic [CNT_W:0] full;
    full = ({{CNT_W{1'b0}}, 1'b1} << s) - {{CNT_W{1'b0}}, 1'b1};
    return full[CNT_W-1:0];
  endfunction

  function automatic logic bypass_mode(input ctrl_reg_t r);
    return r.hosc_on && !r.src_sel && (r.gear == 3'b100);
  endfunction

endpackage

// File: rtl/clkgear_regs.sv
module clkgear_regs
  import clkgear_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [DW-1:0] wdata_i,
  output ctrl_reg_t     ctrl_o,
  output logic          wr_en_o
);

  ctrl_reg_t ctrl_q;
  ctrl_reg_t ctrl_d;

  assign wr_en_o = wr_i && sel_i;

  always_comb begin
    ctrl_d      = ctrl_reg_t'(wdata_i[$bits(ctrl_reg_t)-1:0]);
    ctrl_d.rsvd = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
    end else if (wr_en_o) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/clkgear_switch.sv
module clkgear_switch
  import clkgear_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wrap_i,
  input  logic [GEAR_W-1:0] gear_i,
  output shift_t            act_shift_o,
  output logic              pending_o,
  output logic              apply_o
);

  shift_t act_q;
  logic   pend_q;

  // a write in the wrap cycle keeps the request pending for the next wrap
  assign apply_o = wrap_i && pend_q && !wr_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= gear_to_shift(CTRL_RESET.gear);
      pend_q <= 1'b0;
    end else begin
      if (wrap_i) begin
        act_q <= gear_to_shift(gear_i);
      end
      if (wr_en_i) begin
        pend_q <= 1'b1;
      end else if (wrap_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign act_shift_o = act_q;
  assign pending_o   = pend_q;

endmodule

// File: rtl/clkgear_div.sv
module clkgear_div
  import clkgear_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  shift_t        shift_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          ce_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mask;
  logic [CW-1:0] bit_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign mask = shift_mask(shift_i);

  for (genvar i = 0; i < CW; i++) begin : g_bit
    assign bit_ok[i] = cnt_q[i] || !mask[i];
  end

  assign ce_o   = &bit_ok;
  assign wrap_o = &cnt_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/clkgear_top.sv
module clkgear_top
  import clkgear_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sys_ce,
  output logic       change_done,
  output logic       pll_off,
  output logic       hosc_en,
  output logic       losc_en
);

  ctrl_reg_t        ctrl;
  logic             wr_en;
  logic             wrap;
  logic             pending;
  logic             apply;
  shift_t           act_shift;
  logic [CNT_W-1:0] cnt;

  clkgear_regs #(.DW(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr),
    .sel_i   (reg_sel),
    .wdata_i (reg_wdata),
    .ctrl_o  (ctrl),
    .wr_en_o (wr_en)
  );

  clkgear_switch u_switch (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wrap_i      (wrap),
    .gear_i      (ctrl.gear),
    .act_shift_o (act_shift),
    .pending_o   (pending),
    .apply_o     (apply)
  );

  clkgear_div #(.CW(CNT_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (act_shift),
    .cnt_o   (cnt),
    .wrap_o  (wrap),
    .ce_o    (sys_ce)
  );

  assign reg_rdata   = ctrl;
  assign change_done = !pending;
  assign pll_off     = bypass_mode(ctrl);
  assign hosc_en     = ctrl.hosc_on;
  assign losc_en     = ctrl.losc_on;

endmodule

// File: rtl/clkgear_chk.sv
module clkgear_chk
  import clkgear_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wrap,
  input logic       apply,
  input shift_t     act_shift,
  input logic       sys_ce,
  input logic       change_done,
  input logic       pll_off,
  input logic [7:0] reg_rdata
);

  a_r5_shift_moves_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (act_shift != $past(act_shift)) |-> $past(wrap));

  a_r5_wrap_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> sys_ce);

  a_r6_write_drops_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !change_done);

  a_r6_done_rises_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(change_done) |-> $past(apply));

  a_r4_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_rdata));

  a_r7_bypass_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pll_off));

endmodule

bind clkgear_top clkgear_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wrap        (wrap),
  .apply       (apply),
  .act_shift   (act_shift),
  .sys_ce      (sys_ce),
  .change_done (change_done),
  .pll_off     (pll_off),
  .reg_rdata   (reg_rdata)
);

// File: tb/clkgear_top_bench.sv
`timescale 1ns/1ps
module clkgear_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sys_ce;
  logic       change_done;
  logic       pll_off;
  logic       hosc_en;
  logic       losc_en;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int last_ce = 0;
  bit have_last = 1'b0;
  int trans_ratio = 0;
  bit finished = 1'b0;

  int    exp_iv_q[$];
  string exp_tag_q[$];

  always #2.5 clk = ~clk;

  clkgear_top u_clkgear_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .sys_ce      (sys_ce),
    .change_done (change_done),
    .pll_off     (pll_off),
    .hosc_en     (hosc_en),
    .losc_en     (losc_en)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: time each enable pulse and compare with the scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished && sys_ce) begin
      if (have_last) begin
        if (exp_iv_q.size() > 0) begin
          int    e;
          string t;
          e = exp_iv_q.pop_front();
          t = exp_tag_q.pop_front();
          check((cyc - last_ce) == e, t, cyc - last_ce, e);
        end else if (trans_ratio != 0) begin
          check((cyc - last_ce) == trans_ratio, "R5 old spacing", cyc - last_ce, trans_ratio);
        end
      end
      have_last = 1'b1;
      last_ce   = cyc;
    end
  end

  task automatic push_iv(input int n, input int iv, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_iv_q.push_back(iv);
      exp_tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    while (exp_iv_q.size() > 0) @(negedge clk);
  endtask

  task automatic bus_write(input logic w, input logic s, input logic [7:0] d);
    @(negedge clk);
    reg_wr = w; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00;
  endtask

  // driver: write a new setting, follow the switch, queue intervals of the new gear
  task automatic change_gear(input logic [7:0] d, input int old_iv, input int new_iv,
                             input logic exp_pll, input string tag);
    int waited;
    trans_ratio = old_iv;
    bus_write(1'b1, 1'b1, d);
    check(change_done == 1'b0, "R6 done low after write", change_done, 0);
    check(reg_rdata == (d & 8'h3f), "R4 readback", reg_rdata, d & 8'h3f);
    check(pll_off == exp_pll, "R7 bypass decode", pll_off, exp_pll);
    waited = 0;
    while (!change_done && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    check(waited <= 16, "R6 done within 16 cycles", waited, 16);
    check(last_ce == cyc - 1, "R5 switch follows wrap pulse", last_ce, cyc - 1);
    trans_ratio = 0;
    push_iv(4, new_iv, tag);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reg_rdata == 8'h14, "R1 reset register", reg_rdata, 8'h14);
    check(change_done == 1'b1, "R1 reset done", change_done, 1);
    check(pll_off == 1'b1, "R1 reset bypass", pll_off, 1);
    check(hosc_en == 1'b1 && losc_en == 1'b0, "R8 reset osc enables", {hosc_en, losc_en}, 2);
    push_iv(3, 16, "R1 reset spacing");
    drain();

    // R2 each legal gear
    change_gear(8'h10, 16, 1,  1'b0, "R2 gear 000");
    change_gear(8'h11, 1,  2,  1'b0, "R2 gear 001");
    change_gear(8'h12, 2,  4,  1'b0, "R2 gear 010");
    change_gear(8'h13, 4,  8,  1'b0, "R2 gear 011");
    change_gear(8'h14, 8,  16, 1'b1, "R2 gear 100");
    // R3 out-of-range codes behave as the slowest gear
    change_gear(8'h15, 16, 16, 1'b0, "R3 gear 101");
    change_gear(8'h16, 16, 16, 1'b0, "R3 gear 110");
    change_gear(8'h17, 16, 16, 1'b0, "R3 gear 111");
    // R7 bypass needs all three fields
    change_gear(8'h1C, 16, 16, 1'b0, "R7 select set");
    change_gear(8'h04, 16, 16, 1'b0, "R7 hosc off");
    change_gear(8'h14, 16, 16, 1'b1, "R7 all met");
    // R8 oscillator enables
    change_gear(8'h34, 16, 16, 1'b1, "R8 both on");
    check(hosc_en == 1'b1 && losc_en == 1'b1, "R8 both enables", {hosc_en, losc_en}, 3);
    change_gear(8'h20, 16, 1, 1'b0, "R8 low only");
    check(hosc_en == 1'b0 && losc_en == 1'b1, "R8 low enable only", {hosc_en, losc_en}, 1);
    // R4 reserved bits read zero
    change_gear(8'hD4, 1, 16, 1'b1, "R4 reserved");
    check(reg_rdata == 8'h14, "R4 reserved bits zero", reg_rdata, 8'h14);
    // R4 strobe without address match, and match without strobe
    bus_write(1'b1, 1'b0, 8'h00);
    check(reg_rdata == 8'h14, "R4 no match ignored", reg_rdata, 8'h14);
    check(change_done == 1'b1, "R4 no match keeps done", change_done, 1);
    bus_write(1'b0, 1'b1, 8'h00);
    check(reg_rdata == 8'h14, "R4 no strobe ignored", reg_rdata, 8'h14);
    check(change_done == 1'b1, "R4 no strobe keeps done", change_done, 1);
    push_iv(2, 16, "R4 spacing unchanged");
    drain();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule